// File: doc/BRIEF.md
# Ring-Oscillator PUF Pair Sequencer

This block is the control path of a ring-oscillator physical unclonable function. It sweeps an 8-bit challenge through every pairing of an oscillator from a first bank of 16 with an oscillator from a second bank of 16. For each pairing it drives the enables of exactly those two oscillators and leaves the other 30 stopped to save power. It then waits for the external race arbiter to report a result and records that result as one response bit. A race that ends in a tie is marked in a parallel invalid mask rather than being trusted as a bit.

After all 256 races, the 256-bit response and its 256-bit tie mask are streamed out as sixteen 16-bit words over a valid/ready interface. A single start pulse launches a sweep. A busy flag stays high from the race phase through the end of the stream.

Top module: `puf_pair_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `out_valid` and every bit of `ro_en` are 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle, and `busy` stays high until the handshake of the last output word.
- R3: Races run in challenge order 0 to 255. For challenge c, `ro_en[c[7:4]]` (first bank) and `ro_en[16 + c[3:0]]` (second bank) are high and all other enables are low, so exactly two are high during a race.
- R4: The enables of a pair stay unchanged until `arb_done` is sampled high. All enables are then low for at least one clock before the next pair is driven.
- R5: A race records response bit 1 when `arb_first` is 1 and `arb_tie` is 0 in the cycle `arb_done` is sampled, and records 0 otherwise.
- R6: A race sampled with `arb_tie` = 1 sets its invalid-mask bit to 1 and its response bit to 0, whatever `arb_first` is. Races without a tie set the mask bit to 0.
- R7: The output is 16 words. Word k carries challenges 16k to 16k+15, with challenge 16k at bit 15 and challenge 16k+15 at bit 0. `out_tie_mask` uses the same layout. Word 0 is sent first.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_tie_mask` hold their values. A handshake moves to the next word.
- R9: `start` has no effect while `busy` is high, including the cycle of the last word's handshake.
- R10: `arb_done` has no effect when no race is running, whether idle or streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (honoured only when idle) |
| busy | output | 1 | Sweep or output stream in progress |
| ro_en | output | 32 | Oscillator enables: [15:0] first bank, [31:16] second bank |
| arb_done | input | 1 | Race arbiter result pulse |
| arb_first | input | 1 | First-bank oscillator won the race |
| arb_tie | input | 1 | Race could not be resolved |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Response word |
| out_tie_mask | output | 16 | Invalid-mask word aligned to `out_data` |

## Verification
Two events can coincide. A new `start` can arrive in the same cycle that the last output word is accepted, and a stray `arb_done` can land while words are streaming. The bench drives `start` together with the final handshake and then requires that `busy` drops and no enable rises. It pulses `arb_done` in the middle of the stream and requires that every word still matches the expectation built from the bench's own table of race outcomes. A run of random ready stalls checks that each held word stays stable.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RACE  = 2'd1,
    ST_GAP   = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/puf_seq_ctrl.sv
module puf_seq_ctrl
  import puf_seq_pkg::*;
#(
  parameter int CHAL_W = 8,
  parameter int WORDS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              arb_done,
  input  logic              out_ready,
  output logic [CHAL_W-1:0] chal_next,
  output logic              race_next,
  output logic              capture,
  output logic              word_take,
  output logic              busy,
  output logic              out_valid
);
  localparam int WCNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CHAL_W-1:0] CHAL_LAST = '1;
  localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(WORDS - 1);

  seq_state_t        st_q, st_n;
  logic [CHAL_W-1:0] chal_q, chal_n;
  logic [WCNT_W-1:0] wcnt_q, wcnt_n;

  always_comb begin
    st_n   = st_q;
    chal_n = chal_q;
    wcnt_n = wcnt_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n   = ST_RACE;
        chal_n = '0;
      end
      ST_RACE: if (arb_done) st_n = ST_GAP;
      ST_GAP: begin
        if (chal_q == CHAL_LAST) begin
          st_n   = ST_DRAIN;
          wcnt_n = '0;
        end else begin
          st_n   = ST_RACE;
          chal_n = chal_q + CHAL_W'(1);
        end
      end
      ST_DRAIN: if (out_ready) begin
        wcnt_n = wcnt_q + WCNT_W'(1);
        if (wcnt_q == WCNT_LAST) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      chal_q <= '0;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_n;
      chal_q <= chal_n;
      wcnt_q <= wcnt_n;
    end
  end

  assign chal_next = chal_n;
  assign race_next = (st_n == ST_RACE);
  assign capture   = (st_q == ST_RACE) && arb_done;
  assign word_take = (st_q == ST_DRAIN) && out_ready;
  assign busy      = (st_q != ST_IDLE);
  assign out_valid = (st_q == ST_DRAIN);

  AST_CHAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RACE && $past(st_q) == ST_GAP) |-> chal_q == CHAL_W'($past(chal_q) + CHAL_W'(1))); // R3
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && arb_done && !start) |=> st_q == ST_IDLE); // R10
  AST_START_IN_RACE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RACE && start && !arb_done) |=> st_q == ST_RACE && $stable(chal_q)); // R9
endmodule

// File: rtl/puf_en_decode.sv
module puf_en_decode #(
  parameter int SEL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      race_next,
  input  logic [2*SEL_W-1:0]        chal_next,
  output logic [2*(1<<SEL_W)-1:0]   ro_en
);
  localparam int GRP = 1 << SEL_W;
  localparam int NRO = 2 * GRP;

  logic [NRO-1:0] en_d;
  logic [SEL_W-1:0] sel_a, sel_b;

  assign sel_a = chal_next[2*SEL_W-1:SEL_W];
  assign sel_b = chal_next[SEL_W-1:0];

  for (genvar g = 0; g < GRP; g++) begin : g_bank
    assign en_d[g]       = race_next && (sel_a == SEL_W'(g));
    assign en_d[GRP + g] = race_next && (sel_b == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) ro_en <= '0;
    else     ro_en <= en_d;
  end

  AST_TWO_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (ro_en != '0) |-> ($countones(ro_en[GRP-1:0]) == 1 && $countones(ro_en[NRO-1:GRP]) == 1)); // R3
  AST_PAIR_HELD: assert property (@(posedge clk) disable iff (rst)
    (ro_en != '0 && $past(ro_en) != '0) |-> ro_en == $past(ro_en)); // R4
endmodule

// File: rtl/puf_resp_store.sv
module puf_resp_store #(
  parameter int PAIRS  = 256,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              cap_first,
  input  logic              cap_tie,
  input  logic              word_take,
  output logic [WORD_W-1:0] out_data,
  output logic [WORD_W-1:0] out_tie_mask
);
  logic [PAIRS-1:0] resp_q;
  logic [PAIRS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q <= '0;
      mask_q <= '0;
    end else if (capture) begin
      resp_q <= {resp_q[PAIRS-2:0], cap_first & ~cap_tie};
      mask_q <= {mask_q[PAIRS-2:0], cap_tie};
    end else if (word_take) begin
      resp_q <= resp_q << WORD_W;
      mask_q <= mask_q << WORD_W;
    end
  end

  assign out_data     = resp_q[PAIRS-1 -: WORD_W];
  assign out_tie_mask = mask_q[PAIRS-1 -: WORD_W];

  AST_TIE_ZERO_BIT: assert property (@(posedge clk) disable iff (rst)
    (capture && cap_tie) |=> (resp_q[0] == 1'b0 && mask_q[0] == 1'b1)); // R6
  AST_NO_MIXED_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !(capture && word_take)); // R10
endmodule

// File: rtl/puf_pair_seq.sv
module puf_pair_seq #(
  parameter int SEL_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic [2*(1<<SEL_W)-1:0] ro_en,
  input  logic                    arb_done,
  input  logic                    arb_first,
  input  logic                    arb_tie,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_data,
  output logic [WORD_W-1:0]       out_tie_mask
);
  localparam int CHAL_W = 2 * SEL_W;
  localparam int PAIRS  = 1 << CHAL_W;
  localparam int WORDS  = PAIRS / WORD_W;

  logic [CHAL_W-1:0] chal_next;
  logic              race_next;
  logic              capture;
  logic              word_take;

  puf_seq_ctrl #(.CHAL_W(CHAL_W), .WORDS(WORDS)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .arb_done  (arb_done),
    .out_ready (out_ready),
    .chal_next (chal_next),
    .race_next (race_next),
    .capture   (capture),
    .word_take (word_take),
    .busy      (busy),
    .out_valid (out_valid)
  );

  puf_en_decode #(.SEL_W(SEL_W)) i_dec (
    .clk       (clk),
    .rst       (rst),
    .race_next (race_next),
    .chal_next (chal_next),
    .ro_en     (ro_en)
  );

  puf_resp_store #(.PAIRS(PAIRS), .WORD_W(WORD_W)) i_store (
    .clk          (clk),
    .rst          (rst),
    .capture      (capture),
    .cap_first    (arb_first),
    .cap_tie      (arb_tie),
    .word_take    (word_take),
    .out_data     (out_data),
    .out_tie_mask (out_tie_mask)
  );

  AST_EN_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ro_en != '0) |-> busy); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tie_mask))); // R8
  AST_NO_EN_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ro_en == '0); // R3
endmodule

// File: tb/test_puf_pair_seq.sv
module test_puf_pair_seq;
  localparam int CLK_P = 10;
  localparam int PAIRS = 256;
  localparam int WORDS = 16;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic        busy;
  logic [31:0] ro_en;
  logic        arb_done = 0;
  logic        arb_first = 0;
  logic        arb_tie = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [15:0] out_data;
  logic [15:0] out_tie_mask;

  int n_chk = 0;
  int n_bad = 0;
  int race_idx = 0;
  bit arb_live = 0;
  bit exp_first [PAIRS];
  bit exp_tie   [PAIRS];

  always #(CLK_P/2) clk = ~clk;

  puf_pair_seq i_puf_pair_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .ro_en(ro_en),
    .arb_done(arb_done), .arb_first(arb_first), .arb_tie(arb_tie),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tie_mask(out_tie_mask)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pair_en(input int c);
    logic [7:0] cc = 8'(c);
    return (32'd1 << cc[7:4]) | (32'd1 << (16 + cc[3:0]));
  endfunction

  function automatic logic [15:0] exp_word(input int w, input bit tie_plane);
    logic [15:0] v = '0;
    for (int i = 0; i < 16; i++) begin
      if (tie_plane) v[15-i] = exp_tie[16*w+i];
      else           v[15-i] = exp_first[16*w+i] & ~exp_tie[16*w+i];
    end
    return v;
  endfunction

  // arbiter model: answers each race after a random delay
  initial begin
    int phase = 0;
    int delay = 0;
    logic [31:0] cur = '0;
    forever begin
      @(negedge clk);
      if (arb_live) begin
        arb_done = 0;
        arb_live = 0;
        chk(ro_en == 0, "R4 enables off after done", ro_en, 0);
        phase = 0;
      end else if (phase == 0 && ro_en != 0) begin
        chk(ro_en == pair_en(race_idx), "R3 pair enables", ro_en, pair_en(race_idx));
        cur   = ro_en;
        delay = $urandom_range(0, 4);
        phase = 1;
      end else if (phase == 1) begin
        chk(ro_en == cur, "R4 pair held during race", ro_en, cur);
        if (delay == 0) begin
          arb_done  = 1;
          arb_first = exp_first[race_idx];
          arb_tie   = exp_tie[race_idx];
          race_idx++;
          arb_live  = 1;
          phase     = 2;
        end else delay--;
      end
    end
  end

  task automatic fill(input int mode);
    for (int c = 0; c < PAIRS; c++) begin
      case (mode)
        1: begin exp_first[c] = 1; exp_tie[c] = 0; end
        2: begin exp_first[c] = 1; exp_tie[c] = 1; end
        3: begin exp_first[c] = c[0]; exp_tie[c] = (c % 17 == 0); end
        default: begin
          int r = $urandom_range(0, 9);
          exp_tie[c]   = (r == 0);
          exp_first[c] = r[0];
        end
      endcase
    end
  endtask

  task automatic run_sweep(input int mode, input bit mid_start, input bit end_start,
                           input bit stray, input bit stall);
    int cyc = 0;
    int w = 0;
    bit stalled = 0;
    bit pulsed = 0;
    logic [15:0] held_d = '0;
    logic [15:0] held_t = '0;
    fill(mode);
    race_idx = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R2 busy after start", busy, 1);
    while (!out_valid) begin
      @(negedge clk);
      start = 0;
      cyc++;
      if (mid_start && cyc == 40) start = 1;
      if (!out_valid) chk(busy == 1, "R2 busy during races", busy, 1);
    end
    start = 0;
    chk(race_idx == PAIRS, "R9 one race per challenge", race_idx, PAIRS);
    while (w < WORDS) begin
      if (pulsed && arb_done) arb_done = 0;
      if (stalled) begin
        chk(out_data == held_d && out_tie_mask == held_t, "R8 word held while stalled",
            {out_tie_mask, out_data}, {held_t, held_d});
      end
      chk(out_valid == 1 && busy == 1, "R2 busy while streaming", {busy, out_valid}, 2'b11);
      out_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
      if (stray && w == 5 && !pulsed) begin
        arb_done  = 1;
        arb_first = 1;
        arb_tie   = 1;
        pulsed    = 1;
      end
      if (out_ready) begin
        chk(out_data == exp_word(w, 0), "R5 R7 response word", out_data, exp_word(w, 0));
        chk(out_tie_mask == exp_word(w, 1), "R6 R7 tie mask word", out_tie_mask, exp_word(w, 1));
        w++;
        if (end_start && w == WORDS) start = 1;
      end
      stalled = !out_ready;
      held_d  = out_data;
      held_t  = out_tie_mask;
      @(negedge clk);
    end
    arb_done  = 0;
    out_ready = 0;
    start     = 0;
    chk(busy == 0 && out_valid == 0, "R2 idle after last word", {busy, out_valid}, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && ro_en == 0, "R9 start at last handshake ignored", {busy, ro_en}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (2) @(negedge clk);
    chk(busy == 0 && out_valid == 0 && ro_en == 0, "R1 outputs in reset",
        {busy, out_valid, ro_en}, 0);
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && out_valid == 0 && ro_en == 0, "R1 outputs after reset",
        {busy, out_valid, ro_en}, 0);
    // R10: stray done while idle
    arb_done = 1; arb_first = 1;
    @(negedge clk);
    arb_done = 0;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 0 && ro_en == 0, "R10 done in idle ignored", {busy, ro_en}, 0);
    end
    run_sweep(1, 0, 0, 0, 0);
    run_sweep(2, 0, 0, 0, 1);
    run_sweep(3, 1, 1, 1, 1);
    run_sweep(0, 1, 0, 1, 1);
    run_sweep(0, 0, 1, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule